// File: doc/BRIEF.md
# UART Two-Stage Baud Strobe Generator

This block derives the timing strobes a UART serializer and deserializer need from a fast I/O clock. Software writes one 32-bit divisor word. A 16-bit prescale field sets how many I/O clock cycles make one oversampling period. A 6-bit sample field sets how many oversampling periods make one bit. The number of samples per bit can be programmed from 16 to 64; it is not fixed at 16.

Three single-cycle strobes come out of the block. `sample_tick` fires once per oversampling period. `bit_tick` fires on the last sample of every bit. `mid_tick` fires on the sample at the middle of the bit, where a receiver samples the line. The resulting bit rate is clk / ((prescale + 1) × (sample + 1)). As an example, a prescale of 61 with a sample field of 20 gives 1302 cycles per bit, which is close to 115200 bit/s from a 150 MHz clock.

Each write of the divisor restarts both counters, so a new rate takes effect on a clean bit boundary.

Top module: `baud_strobe_gen`

## Requirements
- R1: While reset is asserted, all three strobes are 0. After reset the divisor holds prescale 0 and sample field 15, so a bit lasts 16 clock cycles and `sample_tick` fires every cycle.
- R2: The prescale value P is taken from `div_wdata[15:0]`. `sample_tick` fires exactly every P+1 clock cycles.
- R3: The sample field S is taken from `div_wdata[21:16]`. `bit_tick` fires together with every (S+1)-th `sample_tick`, so one bit lasts (P+1)×(S+1) cycles.
- R4: `mid_tick` fires together with the `sample_tick` whose zero-based index within the bit is floor(S/2). It never coincides with `bit_tick`.
- R5: A write (`div_wr` high at a rising edge) clears both counters. No strobe is high in the cycle after that edge. Counting from that edge, the first `sample_tick` comes P+1 cycles later, the first `mid_tick` (P+1)×(floor(S/2)+1) cycles later, and the first `bit_tick` (P+1)×(S+1) cycles later.
- R6: A written sample field below 15 is stored as 15.
- R7: Bits [31:22] of `div_wdata` have no effect.
- R8: The largest prescale value, 0xFFFF, gives a sample period of 65536 cycles.
- R9: The divisor word 0x0014003D gives a bit period of 1302 cycles. This is within 0.5 % of 115200 bit/s at a 150 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 32 | Divisor word: prescale in [15:0], sample field in [21:16] |
| sample_tick | output | 1 | One-cycle pulse per oversampling period |
| mid_tick | output | 1 | One-cycle pulse at the middle sample of each bit |
| bit_tick | output | 1 | One-cycle pulse at the last sample of each bit |

## Verification
A wrong prescale count shows up as a `sample_tick` spacing other than P+1. This is visible within one sample period, and the bench measures it from the write edge. A wrong sample counter or a wrong clamp appears at the first `bit_tick` or `mid_tick` after a write, which arrives within one bit period. The bench compares those arrival cycles, and the number of sample strobes per bit, against the formulas. A restart that fails to clear the counters moves the first strobes after a rewrite of the same value, and the bench catches this within one bit.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int DIV_DATA_W   = 32;
  localparam int DIV_PRE_W    = 16;
  localparam int DIV_SMP_W    = 6;
  localparam int DIV_SMP_MIN  = 15;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int DATA_W  = 32,
  parameter int PRE_W   = 16,
  parameter int SMP_W   = 6,
  parameter int SMP_MIN = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRE_W-1:0]  pre_q,
  output logic [SMP_W-1:0]  smp_q
);
  localparam int SMP_LSB = PRE_W;
  localparam int SMP_MSB = SMP_LSB + SMP_W - 1;

  logic [SMP_W-1:0] smp_field;
  logic [SMP_W-1:0] smp_clamped;
  logic [PRE_W-1:0] pre_d;
  logic [SMP_W-1:0] smp_d;
  logic             unused_hi;

  assign unused_hi   = ^wdata[DATA_W-1:SMP_MSB+1];
  assign smp_field   = wdata[SMP_MSB:SMP_LSB];
  assign smp_clamped = (smp_field < SMP_W'(SMP_MIN)) ? SMP_W'(SMP_MIN) : smp_field;

  always_comb begin
    pre_d = pre_q;
    smp_d = smp_q;
    if (wr) begin
      pre_d = wdata[PRE_W-1:0];
      smp_d = smp_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      smp_q <= SMP_W'(SMP_MIN);
    end else if (wr) begin
      pre_q <= pre_d;
      smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/baud_wrap_ctr.sv
module baud_wrap_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] count_d;
  logic         load;

  assign wrap = en && (count == limit);
  assign load = clr || en;

  always_comb begin
    count_d = count;
    if (clr)       count_d = '0;
    else if (wrap) count_d = '0;
    else if (en)   count_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= count_d;
  end
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen
  import baud_pkg::*;
#(
  parameter int DATA_W  = DIV_DATA_W,
  parameter int PRE_W   = DIV_PRE_W,
  parameter int SMP_W   = DIV_SMP_W,
  parameter int SMP_MIN = DIV_SMP_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic [DATA_W-1:0] div_wdata,
  output logic              sample_tick,
  output logic              mid_tick,
  output logic              bit_tick
);
  logic             rst_meta_n;
  logic             rst_sync_n;
  logic [PRE_W-1:0] pre_q;
  logic [SMP_W-1:0] smp_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [SMP_W-1:0] smp_cnt;
  logic             pre_wrap;
  logic             smp_en;
  logic             smp_wrap;
  logic             sample_d, mid_d, bit_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  baud_div_reg #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .SMP_W(SMP_W), .SMP_MIN(SMP_MIN)
  ) i_div_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr(div_wr), .wdata(div_wdata),
    .pre_q(pre_q), .smp_q(smp_q)
  );

  // first stage: I/O clock cycles per sample
  baud_wrap_ctr #(.W(PRE_W)) i_pre_ctr (
    .clk(clk), .rst_n(rst_sync_n), .clr(div_wr), .en(1'b1),
    .limit(pre_q), .count(pre_cnt), .wrap(pre_wrap)
  );

  assign smp_en = pre_wrap && !div_wr;

  // second stage: samples per bit
  baud_wrap_ctr #(.W(SMP_W)) i_smp_ctr (
    .clk(clk), .rst_n(rst_sync_n), .clr(div_wr), .en(smp_en),
    .limit(smp_q), .count(smp_cnt), .wrap(smp_wrap)
  );

  always_comb begin
    sample_d = smp_en;
    bit_d    = smp_wrap && !div_wr;
    mid_d    = smp_en && (smp_cnt == (smp_q >> 1));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sample_tick <= 1'b0;
      mid_tick    <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= sample_d;
      mid_tick    <= mid_d;
      bit_tick    <= bit_d;
    end
  end
endmodule

// File: rtl/baud_strobe_chk.sv
module baud_strobe_chk #(
  parameter int DATA_W  = 32,
  parameter int PRE_W   = 16,
  parameter int SMP_W   = 6,
  parameter int SMP_MIN = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              div_wr,
  input logic [DATA_W-1:0] div_wdata,
  input logic              sample_tick,
  input logic              mid_tick,
  input logic              bit_tick
);
  logic [PRE_W-1:0] exp_p;
  logic [SMP_W-1:0] exp_s;
  logic [PRE_W:0]   gap;
  logic [SMP_W:0]   scnt;
  logic [SMP_W-1:0] wr_s;
  logic             unused_bits;

  assign unused_bits = ^div_wdata[DATA_W-1:PRE_W+SMP_W];
  assign wr_s = div_wdata[PRE_W+SMP_W-1:PRE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_p <= '0;
      exp_s <= SMP_W'(SMP_MIN);
      gap   <= '0;
      scnt  <= '0;
    end else begin
      if (div_wr) begin
        exp_p <= div_wdata[PRE_W-1:0];
        exp_s <= (wr_s < SMP_W'(SMP_MIN)) ? SMP_W'(SMP_MIN) : wr_s;
        gap   <= '0;
        scnt  <= '0;
      end else begin
        gap <= sample_tick ? (PRE_W+1)'(1) : gap + (PRE_W+1)'(1);
        if (sample_tick) scnt <= bit_tick ? '0 : scnt + (SMP_W+1)'(1);
      end
    end
  end

  // R2
  sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> gap == ({1'b0, exp_p} + (PRE_W+1)'(1)));
  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> scnt == {1'b0, exp_s});
  // R3
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  // R4
  mid_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> sample_tick);
  // R4
  mid_bit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mid_tick && bit_tick));
  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> !(sample_tick || mid_tick || bit_tick));
endmodule

bind baud_strobe_gen baud_strobe_chk #(
  .DATA_W(DATA_W), .PRE_W(PRE_W), .SMP_W(SMP_W), .SMP_MIN(SMP_MIN)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .div_wr(div_wr), .div_wdata(div_wdata),
  .sample_tick(sample_tick), .mid_tick(mid_tick), .bit_tick(bit_tick)
);

// File: tb/test_baud_strobe_gen.sv
module test_baud_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        div_wr;
  logic [31:0] div_wdata;
  logic        sample_tick, mid_tick, bit_tick;
  int          n_run = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  baud_strobe_gen i_baud_strobe_gen (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .sample_tick(sample_tick), .mid_tick(mid_tick), .bit_tick(bit_tick)
  );

  localparam int NV = 8;
  localparam logic [31:0] VEC_W [NV] = '{
    32'h000F_0000, 32'h000F_0002, 32'h003F_0001, 32'h0014_003D,
    32'h0005_0003, 32'h0000_0001, 32'hFFD0_0004, 32'h0010_0000};
  localparam int VEC_P [NV] = '{0, 2, 1, 61, 3, 1, 4, 0};
  localparam int VEC_S [NV] = '{15, 15, 63, 20, 15, 15, 16, 16};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      finish_run();
    end
  end

  task automatic write_div(input logic [31:0] w);
    @(negedge clk);
    div_wr = 1'b1;
    div_wdata = w;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] w, input int p, input int s,
                         input string req, output int per);
    int bitp, fs, fm, fb, sb, nsamp;
    bitp = (p + 1) * (s + 1);
    fs = -1; fm = -1; fb = -1; sb = -1; nsamp = 0;
    write_div(w);
    for (int j = 0; j <= 2 * bitp + 2 && sb < 0; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 0)
        check(!(sample_tick || mid_tick || bit_tick), "R5", "strobes right after write",
              int'({sample_tick, mid_tick, bit_tick}), 0);
      if (sample_tick && fs < 0) fs = j;
      if (mid_tick && fm < 0) fm = j;
      if (sample_tick && fb < 0) nsamp++;
      if (bit_tick) begin
        if (fb < 0) fb = j;
        else if (sb < 0) sb = j;
      end
    end
    per = sb - fb;
    check(fs == p + 1, "R2", {req, " first sample"}, fs, p + 1);
    check(fm == (p + 1) * (s / 2 + 1), "R4", {req, " first mid"}, fm, (p + 1) * (s / 2 + 1));
    check(fb == bitp, "R5", {req, " first bit"}, fb, bitp);
    check(nsamp == s + 1, "R3", {req, " samples per bit"}, nsamp, s + 1);
    check(per == bitp, "R3", {req, " bit period"}, per, bitp);
  endtask

  initial begin
    int per, b1, b2, ns, fs, rate;
    rst_n = 1'b1;
    div_wr = 1'b0;
    div_wdata = '0;
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!(sample_tick || mid_tick || bit_tick), "R1", "strobes in reset",
          int'({sample_tick, mid_tick, bit_tick}), 0);
    rst_n = 1'b1;
    b1 = -1; b2 = -1; ns = 0;
    for (int j = 0; j < 100 && b2 < 0; j++) begin
      @(negedge clk);
      if (b1 >= 0 && sample_tick) ns++;
      if (bit_tick) begin
        if (b1 < 0) b1 = j;
        else b2 = j;
      end
    end
    check(b2 - b1 == 16, "R1", "default bit period", b2 - b1, 16);
    check(ns == 16, "R1", "default samples per bit", ns, 16);

    for (int v = 0; v < NV; v++) begin
      string req;
      req = (v == 4 || v == 5) ? "R6" : (v == 6) ? "R7" : "R2";
      run_vec(VEC_W[v], VEC_P[v], VEC_S[v], req, per);
      if (v == 3) begin
        rate = 150000000 / per;
        check(per == 1302, "R9", "bit period for 115200", per, 1302);
        check(rate >= 115200 - 576 && rate <= 115200 + 576, "R9", "bit rate", rate, 115200);
      end
    end

    // restart: rewrite the same value mid-bit
    write_div(32'h000F_0002);
    repeat (30) @(negedge clk);
    run_vec(32'h000F_0002, 2, 15, "R5 restart", per);

    // largest prescale
    write_div(32'h000F_FFFF);
    fs = -1;
    for (int j = 0; j <= 65540 && fs < 0; j++) begin
      if (j > 0) @(negedge clk);
      if (sample_tick) fs = j;
    end
    check(fs == 65536, "R8", "max prescale sample period", fs, 65536);

    finish_run();
  end
endmodule